// File: doc/BRIEF.md
# Burst Carrier Timer Pair

The block holds two 8-bit down-counting timers. Each timer reloads from its own reload register when it underflows. The second timer is the carrier timer. It alternates between a low reload value and a high reload value, and on each phase end it flips a square carrier. Its ticks come either from every system clock cycle or from every second cycle. As an option, the high phase can be stretched by one extra tick. The first timer is the burst timer. It counts either rising edges of the carrier or rising edges of an external watchdog tap, which is synchronised into the clock domain first.

When automatic gating is on, each burst-timer underflow flips a gate. The output pin then carries the carrier only while that gate is open, so the pin shows bursts of carrier pulses separated by silent windows.

Software programs the block through a simple write port. A combinational read port returns either timer's value. Each timer also drives a one-cycle underflow pulse. Writing zero to the high reload register while high-phase stretching is active raises a one-cycle error pulse.

Top module: `burst_carrier_timer`

## Requirements
- R1: After reset, both control registers and both counters are 0. The pin, both underflow pulses and the error pulse are low, and reads of either timer return 0.
- R2: Writes use these addresses: 0 = burst control, 1 = carrier control, 2 = burst reload, 3 = carrier low reload, 4 = carrier high reload.
  - Burst control bits: bit0 run, bit1 source (0 carrier, 1 watchdog tap), bit2 automatic gating.
  - Carrier control bits: bit0 run, bit1 rate (0 every cycle, 1 every second cycle), bit2 carrier enable, bit3 high stretch.
  - A write to reload 2 or reload 3 while the matching timer is stopped also presets that counter.
- R3: After a timer is started, it counts only from the first rising source edge that follows a falling source edge. At every-cycle rate, the first tick comes one cycle after the start write takes effect, so the first carrier-timer underflow comes low-reload+1 cycles after the start.
- R4: While the carrier is enabled, the low phase lasts low-reload+1 ticks and the high phase lasts high-reload+1 ticks. One tick is one clock cycle at every-cycle rate, or two cycles at every-second-cycle rate.
- R5: With both carrier enable and high stretch set, the high phase lasts high-reload+2 ticks.
- R6: A write of 0 to the high reload while carrier enable and high stretch are both set gives a one-cycle error pulse in the cycle after the write. No other write produces the pulse.
- R7: A reload value written while its timer runs is used at that timer's next reload.
- R8: A write to a control register while that timer runs leaves its source/rate bit unchanged and applies the other bits.
- R9: The read port returns the live count of a stopped timer. For a running timer it returns the count held when the timer was last stopped.
- R10: With automatic gating on, each burst-timer underflow flips the gate, and the pin is the carrier ANDed with the gate. With the burst timer counting the carrier and reload N, each burst shows N+2 pin rising edges: N+1 carrier periods, with clipped pulses at both ends.
- R11: With automatic gating off, the pin follows the carrier. With carrier enable clear, the pin stays low.
- R12: Each underflow gives one pulse on that timer's underflow output, one cycle wide.
- R13: With the watchdog source selected, the burst timer counts rising edges of the synchronised tap, giving one underflow per reload+1 tap periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_sel | input | 1 | Read select: 0 burst timer, 1 carrier timer |
| rd_data | output | 8 | Read value of the selected timer |
| wdt_tap | input | 1 | Watchdog divider tap, asynchronous |
| carrier_pin | output | 1 | Gated carrier output |
| t1_uf | output | 1 | Burst timer underflow pulse |
| t2_uf | output | 1 | Carrier timer underflow pulse |
| high_zero_err | output | 1 | Pulse for a zero high reload written while stretch is active |

## Verification
The hardest condition to reach from the ports is burst gating. In that case the gate opens and closes a fixed delay after a carrier rising edge, which clips the first and last pulse of each burst. The stimulus sets the carrier phases long enough that both clipped pulses are still visible. It then lets the block run freely, synchronises on a low gap longer than any carrier low phase, and counts pin rising edges until the next such gap.

The start rule is brought out through the read port. The bench stops the carrier timer a known number of cycles after starting it and compares the held count against one computed with the arming delay included.

// File: rtl/bct_pkg.sv
package bct_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTL1  = 3'd0,
    REG_CTL2  = 3'd1,
    REG_RLD1  = 3'd2,
    REG_RLD2L = 3'd3,
    REG_RLD2H = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic auto_gate;
    logic src_wdt;
    logic run;
  } t1_ctl_t;

  typedef struct packed {
    logic stretch_en;
    logic gen_en;
    logic src_half;
    logic run;
  } t2_ctl_t;
endpackage

// File: rtl/bct_level_edge.sv
module bct_level_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/bct_start_gate.sv
module bct_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rise,
  input  logic fall,
  output logic tick
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (!run)      armed_d = 1'b0;
    else if (fall) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign tick = run & armed_q & rise;

  // R3: no count in the first cycle of a run
  a_r3_no_tick_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> !tick);
endmodule

// File: rtl/bct_down_counter.sv
module bct_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         preset_en,
  input  logic [W-1:0] preset_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] read_val,
  output logic         uf
);
  logic [W-1:0] cnt_q, cnt_d, snap_q, snap_d;

  assign uf = run & tick & (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (preset_en)       cnt_d = preset_val;
    else if (uf)         cnt_d = reload_val;
    else if (run && tick) cnt_d = cnt_q - 1'b1;
    snap_d = run ? snap_q : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      snap_q <= snap_d;
    end
  end

  assign read_val = run ? snap_q : cnt_q;

  // R7: an underflow loads the reload value offered at that cycle
  a_r7_uf_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !preset_en) |=> cnt_q == $past(reload_val));
  // R9: a stopped counter without preset keeps its value
  a_r9_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !preset_en) |=> $stable(cnt_q));
endmodule

// File: rtl/burst_carrier_timer.sv
module burst_carrier_timer #(
  parameter int CW       = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [bct_pkg::ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]             wr_data,
  input  logic                      rd_sel,
  output logic [CW-1:0]             rd_data,
  input  logic                      wdt_tap,
  output logic                      carrier_pin,
  output logic                      t1_uf,
  output logic                      t2_uf,
  output logic                      high_zero_err
);
  import bct_pkg::*;

  localparam int T1_CTL_W = $bits(t1_ctl_t);
  localparam int T2_CTL_W = $bits(t2_ctl_t);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  // programmable state
  t1_ctl_t       ctl1_q, ctl1_d;
  t2_ctl_t       ctl2_q, ctl2_d;
  logic [CW-1:0] rld1_q, rld1_d, rld2l_q, rld2l_d, rld2h_q, rld2h_d;
  logic          err_q, err_d;
  logic          pre1, pre2;

  always_comb begin
    ctl1_d  = ctl1_q;
    ctl2_d  = ctl2_q;
    rld1_d  = rld1_q;
    rld2l_d = rld2l_q;
    rld2h_d = rld2h_q;
    err_d   = 1'b0;
    pre1    = 1'b0;
    pre2    = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        REG_CTL1: begin
          ctl1_d = t1_ctl_t'(wr_data[T1_CTL_W-1:0]);
          if (ctl1_q.run) ctl1_d.src_wdt = ctl1_q.src_wdt;
        end
        REG_CTL2: begin
          ctl2_d = t2_ctl_t'(wr_data[T2_CTL_W-1:0]);
          if (ctl2_q.run) ctl2_d.src_half = ctl2_q.src_half;
        end
        REG_RLD1: begin
          rld1_d = wr_data;
          pre1   = ~ctl1_q.run;
        end
        REG_RLD2L: begin
          rld2l_d = wr_data;
          pre2    = ~ctl2_q.run;
        end
        REG_RLD2H: begin
          rld2h_d = wr_data;
          err_d   = (wr_data == '0) & ctl2_q.gen_en & ctl2_q.stretch_en;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl1_q  <= '0;
      ctl2_q  <= '0;
      rld1_q  <= '0;
      rld2l_q <= '0;
      rld2h_q <= '0;
      err_q   <= 1'b0;
    end else begin
      ctl1_q  <= ctl1_d;
      ctl2_q  <= ctl2_d;
      rld1_q  <= rld1_d;
      rld2l_q <= rld2l_d;
      rld2h_q <= rld2h_d;
      err_q   <= err_d;
    end
  end

  assign high_zero_err = err_q;

  // watchdog tap synchroniser, depth picked by parameter
  logic wdt_s;
  generate
    if (SYNC_LEN <= 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) s_q <= 1'b0;
        else         s_q <= wdt_tap;
      end
      assign wdt_s = s_q;
    end else begin : g_syncn
      logic [SYNC_LEN-1:0] s_q;
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= {s_q[SYNC_LEN-2:0], wdt_tap};
      end
      assign wdt_s = s_q[SYNC_LEN-1];
    end
  endgenerate

  // carrier timer: tick source
  logic div_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= ~div_q;
  end

  logic t2_rise, t2_fall, t2_tick, t2_cnt_uf;
  assign t2_rise = ctl2_q.src_half ? div_q  : 1'b1;
  assign t2_fall = ctl2_q.src_half ? ~div_q : 1'b1;

  bct_start_gate i_t2_gate (
    .clk  (clk),
    .rst_n(rst_ni),
    .run  (ctl2_q.run),
    .rise (t2_rise),
    .fall (t2_fall),
    .tick (t2_tick)
  );

  // carrier phase control
  logic          carr_q, carr_d, stretch_q, stretch_d;
  logic          ext_eff, stretch_now, phase_end;
  logic [CW-1:0] t2_reload, t2_rd;

  assign ext_eff     = ctl2_q.gen_en & ctl2_q.stretch_en;
  assign stretch_now = carr_q & ext_eff & ~stretch_q;
  assign phase_end   = t2_cnt_uf & ~stretch_now;

  always_comb begin
    if (!ctl2_q.gen_en)   t2_reload = rld2l_q;
    else if (stretch_now) t2_reload = '0;
    else if (carr_q)      t2_reload = rld2l_q;
    else                  t2_reload = rld2h_q;
  end

  always_comb begin
    carr_d    = carr_q;
    stretch_d = stretch_q;
    if (!ctl2_q.gen_en) begin
      carr_d    = 1'b0;
      stretch_d = 1'b0;
    end else if (t2_cnt_uf) begin
      stretch_d = stretch_now;
      if (phase_end) carr_d = ~carr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      carr_q    <= 1'b0;
      stretch_q <= 1'b0;
    end else begin
      carr_q    <= carr_d;
      stretch_q <= stretch_d;
    end
  end

  bct_down_counter #(.W(CW)) i_t2_cnt (
    .clk       (clk),
    .rst_n     (rst_ni),
    .run       (ctl2_q.run),
    .tick      (t2_tick),
    .preset_en (pre2),
    .preset_val(rld2l_d),
    .reload_val(t2_reload),
    .read_val  (t2_rd),
    .uf        (t2_cnt_uf)
  );

  assign t2_uf = phase_end;

  // burst timer
  logic          t1_lvl, t1_rise, t1_fall, t1_tick, t1_cnt_uf;
  logic [CW-1:0] t1_rd;
  assign t1_lvl = ctl1_q.src_wdt ? wdt_s : carr_q;

  bct_level_edge i_t1_edge (
    .clk  (clk),
    .rst_n(rst_ni),
    .lvl  (t1_lvl),
    .rise (t1_rise),
    .fall (t1_fall)
  );

  bct_start_gate i_t1_gate (
    .clk  (clk),
    .rst_n(rst_ni),
    .run  (ctl1_q.run),
    .rise (t1_rise),
    .fall (t1_fall),
    .tick (t1_tick)
  );

  bct_down_counter #(.W(CW)) i_t1_cnt (
    .clk       (clk),
    .rst_n     (rst_ni),
    .run       (ctl1_q.run),
    .tick      (t1_tick),
    .preset_en (pre1),
    .preset_val(rld1_d),
    .reload_val(rld1_q),
    .read_val  (t1_rd),
    .uf        (t1_cnt_uf)
  );

  assign t1_uf = t1_cnt_uf;

  // burst gate
  logic gate_q, gate_d;
  always_comb begin
    gate_d = gate_q;
    if (!ctl1_q.auto_gate) gate_d = 1'b0;
    else if (t1_cnt_uf)    gate_d = ~gate_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_d;
  end

  assign carrier_pin = ctl2_q.gen_en & carr_q & (~ctl1_q.auto_gate | gate_q);
  assign rd_data     = rd_sel ? t2_rd : t1_rd;

  // R8: source/rate bit frozen while running
  a_r8_t1_src_locked: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_addr == REG_CTL1 && ctl1_q.run) |=> ctl1_q.src_wdt == $past(ctl1_q.src_wdt));
  a_r8_t2_src_locked: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_addr == REG_CTL2 && ctl2_q.run) |=> ctl2_q.src_half == $past(ctl2_q.src_half));
  // R6: zero high reload under stretch is flagged
  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_addr == REG_RLD2H && wr_data == '0 && ext_eff) |=> high_zero_err);
  // R10: gate flips on each burst-timer underflow
  a_r10_gate_flip: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl1_q.auto_gate && t1_uf) |=> gate_q != $past(gate_q));
  // R5: the extra tick only ever extends a high phase
  a_r5_stretch_in_high: assert property (@(posedge clk) disable iff (!rst_ni)
    stretch_q |-> carr_q);
endmodule

// File: tb/test_burst_carrier_timer.sv
module test_burst_carrier_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       rd_sel;
  logic [7:0] rd_data;
  logic       wdt_tap;
  logic       carrier_pin, t1_uf, t2_uf, high_zero_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_carrier_timer i_burst_carrier_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_sel       (rd_sel),
    .rd_data      (rd_data),
    .wdt_tap      (wdt_tap),
    .carrier_pin  (carrier_pin),
    .t1_uf        (t1_uf),
    .t2_uf        (t2_uf),
    .high_zero_err(high_zero_err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WD_LIMIT) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_sel = 1'b0; wdt_tap = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // measures one full carrier period on the pin, in cycles
  task automatic measure(string tag, int exp_h, int exp_l);
    int h = 0;
    int l = 0;
    int g = 0;
    while (carrier_pin !== 1'b0 && g < 2000) begin @(negedge clk); g++; end
    while (carrier_pin !== 1'b1 && g < 4000) begin @(negedge clk); g++; end
    while (carrier_pin === 1'b1 && h < 2000) begin @(negedge clk); h++; end
    while (carrier_pin === 1'b0 && l < 2000) begin @(negedge clk); l++; end
    chk({tag, " high"}, h, exp_h);
    chk({tag, " low"}, l, exp_l);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pin", carrier_pin, 0);
    chk("R1 uf1", t1_uf, 0);
    chk("R1 uf2", t2_uf, 0);
    chk("R1 err", high_zero_err, 0);
    rd_sel = 1'b0; #1;
    chk("R1 read t1", rd_data, 0);
    rd_sel = 1'b1; #1;
    chk("R1 read t2", rd_data, 0);
  endtask

  task automatic t_first_uf();
    int first = -1;
    int second = -1;
    int wide = 0;
    logic prev = 1'b0;
    do_reset();
    wr(3'd3, 8'd3);
    wr(3'd1, 8'h01);
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (t2_uf && first < 0) first = i;
      else if (t2_uf && second < 0 && !prev) second = i;
      if (t2_uf && prev) wide++;
      if (carrier_pin) wide += 100;
      prev = t2_uf;
    end
    chk("R3 first underflow delay", first, 4);
    chk("R3 later underflow spacing", second - first, 4);
    chk("R12 t2 pulse width / R11 pin low when disabled", wide, 0);
  endtask

  task automatic t_read();
    do_reset();
    wr(3'd3, 8'd5);
    rd_sel = 1'b1; #1;
    chk("R2 preset on stopped write, R9 read stopped", rd_data, 5);
    wr(3'd1, 8'h01);
    repeat (3) @(negedge clk);
    chk("R9 read while running holds stop value", rd_data, 5);
    wr(3'd1, 8'h00);
    chk("R9 read after stop", rd_data, 1);
    repeat (5) @(negedge clk);
    chk("R9 stopped value stable", rd_data, 1);
  endtask

  task automatic t_duty_full();
    do_reset();
    wr(3'd3, 8'd2); wr(3'd4, 8'd3);
    wr(3'd1, 8'h05);
    measure("R4 R11 full rate 3/2", 4, 3);
    do_reset();
    wr(3'd3, 8'd5); wr(3'd4, 8'd0);
    wr(3'd1, 8'h05);
    measure("R4 full rate 0/5", 1, 6);
  endtask

  task automatic t_duty_half();
    do_reset();
    wr(3'd3, 8'd1); wr(3'd4, 8'd2);
    wr(3'd1, 8'h07);
    measure("R4 half rate 2/1", 6, 4);
  endtask

  task automatic t_extend();
    do_reset();
    wr(3'd3, 8'd2); wr(3'd4, 8'd3);
    wr(3'd1, 8'h0D);
    measure("R5 stretched high", 5, 3);
  endtask

  task automatic t_reload_live();
    do_reset();
    wr(3'd3, 8'd2); wr(3'd4, 8'd3);
    wr(3'd1, 8'h05);
    measure("R7 before reload write", 4, 3);
    wr(3'd4, 8'd6);
    measure("R7 after reload write", 7, 3);
  endtask

  task automatic t_src_lock();
    do_reset();
    wr(3'd3, 8'd2); wr(3'd4, 8'd3);
    wr(3'd1, 8'h05);
    wr(3'd1, 8'h07);
    measure("R8 rate bit ignored while running", 4, 3);
  endtask

  task automatic t_zero_flag();
    do_reset();
    wr(3'd1, 8'h0C);
    wr(3'd4, 8'd0);
    chk("R6 zero high flagged", high_zero_err, 1);
    @(negedge clk);
    chk("R6 flag one cycle", high_zero_err, 0);
    wr(3'd4, 8'd4);
    chk("R6 nonzero not flagged", high_zero_err, 0);
    wr(3'd1, 8'h04);
    wr(3'd4, 8'd0);
    chk("R6 no flag without stretch", high_zero_err, 0);
  endtask

  task automatic t_burst();
    int lowrun = 0;
    int g = 0;
    do_reset();
    wr(3'd3, 8'd4); wr(3'd4, 8'd3);
    wr(3'd2, 8'd3);
    wr(3'd0, 8'h05);
    wr(3'd1, 8'h05);
    while (lowrun < 15 && g < 3000) begin
      @(negedge clk); g++;
      lowrun = carrier_pin ? 0 : lowrun + 1;
    end
    for (int b = 0; b < 2; b++) begin
      int rises = 0;
      logic prev = 1'b0;
      lowrun = 0;
      g = 0;
      while (!(rises > 0 && lowrun >= 15) && g < 3000) begin
        @(negedge clk); g++;
        if (carrier_pin && !prev) rises++;
        lowrun = carrier_pin ? 0 : lowrun + 1;
        prev = carrier_pin;
      end
      chk("R10 pin rises per burst", rises, 5);
    end
  endtask

  task automatic t_wdt();
    int first = -1;
    int second = -1;
    int wide = 0;
    logic prev = 1'b0;
    do_reset();
    wr(3'd2, 8'd2);
    wr(3'd0, 8'h03);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i % 4 == 0) wdt_tap = ~wdt_tap;
      if (t1_uf && !prev) begin
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
      if (t1_uf && prev) wide++;
      prev = t1_uf;
    end
    chk("R13 watchdog source underflow spacing", second - first, 24);
    chk("R12 t1 pulse width", wide, 0);
    chk("R13 pin stays low", carrier_pin, 0);
  endtask

  initial begin
    t_reset();
    t_first_uf();
    t_read();
    t_duty_full();
    t_duty_half();
    t_extend();
    t_reload_live();
    t_src_lock();
    t_zero_flag();
    t_burst();
    t_wdt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule